// File: doc/BRIEF.md
# Memory bank chip-select controller

This block decides, for a single external memory bank, whether a bus cycle belongs to that bank and then runs the cycle. The cycle logic drives the chip-select, the transfer acknowledge and the parity-check enable. A bus master starts a cycle by pulsing the address strobe for one clock, with the address, the direction, the master type and the synchronous flag valid in that clock. The bank is claimed when its valid bit is set and the address agrees with the base value on every bit the mask selects. A claimed cycle runs a programmed number of wait states plus two phases. Each phase is one clock of the controller clock, which runs at twice the bus rate. The cycle ends on its own.

Each bank has a configuration register with these fields: valid, write protect, parity enable, early release, bank type (SRAM or DRAM), wait count, base and mask. Writing the register mid-cycle does not disturb the cycle in flight, because the fields a cycle uses are captured when it starts. A write to a protected bank produces neither a chip-select nor an acknowledge. Instead it sets a sticky error flag, and it can request a bus error. The early-release option drops chip-select one phase before the end of a write, and the cycle length stays the same.

Top module: `csb_bank_ctrl`

## Requirements
- R1: While reset is held and after it is released, cs_o, ack_o, berr_o, par_chk_o and wp_err_o are 0. The reset contents of the register are as follows:
  - When IS_BANK0=1, valid takes the value of gcs_en_i; otherwise valid is 0.
  - Every other field is 0, so the bank has zero wait states and a mask of all zeros, which matches every address.
- R2: When the bank's valid bit is 0, no strobe ever produces cs_o or ack_o, and the cycle is left unterminated.
- R3: An address is claimed when ((bus_addr_i XOR base) AND mask) is zero. A strobe that misses produces no output activity at all.
- R4: A claimed cycle lasts L = waits+2 clocks. The clock after the strobe edge is phase 1, and cs_o rises in phase 1. ack_o is high for exactly one clock, in phase L. All outputs are idle in phase L+1.
- R5: When write protect is 1, reads run normally, but a write produces neither cs_o nor ack_o.
- R6: A write to a protected bank sets wp_err_o from the clock after the strobe. The flag stays set until stat_clr_i is 1 at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R7: A protected write with bmon_en_i=1 raises berr_o for exactly one clock, in phase 1. With bmon_en_i=0, berr_o stays at 0.
- R8: par_chk_o is high for all L clocks of a claimed cycle when parity enable is 1. When parity enable is 0, par_chk_o stays at 0.
- R9: par_chk_o stays at 0 for a cycle started with bus_ext_i=1 and bus_sync_i=0, whatever the parity enable bit is set to.
- R10: When early release is 1, cs_o is low in phase L of a write, so cs_o is high for L-1 clocks. Reads, the value of L and the timing of ack_o are unchanged.
- R11: Early release has no effect on an SRAM bank (bank type 0) when the cycle is started with bus_ext_i=1 and bus_sync_i=0.
- R12: A configuration write during a cycle changes neither that cycle's length, nor its chip-select shape, nor its parity enable.
- R13: An address strobe that arrives while a cycle is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| gcs_en_i | input | 1 | Global chip-select strap, sets the reset value of valid |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_valid_i | input | 1 | Bank valid field |
| cfg_wprot_i | input | 1 | Write protect field |
| cfg_par_en_i | input | 1 | Parity enable field |
| cfg_early_i | input | 1 | Early chip-select release field |
| cfg_dram_i | input | 1 | Bank type field (1 = DRAM, 0 = SRAM) |
| cfg_waits_i | input | WAIT_W | Wait-state count field |
| cfg_base_i | input | AW | Base address field |
| cfg_mask_i | input | AW | Address mask field |
| stat_clr_i | input | 1 | Write-one clear of the protection error flag |
| bmon_en_i | input | 1 | Bus monitor enable, allows a bus error request |
| bus_as_i | input | 1 | Address strobe, one-clock pulse that starts a cycle |
| bus_addr_i | input | AW | Cycle address |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_ext_i | input | 1 | 1 = external master |
| bus_sync_i | input | 1 | 1 = synchronous master |
| cs_o | output | 1 | Chip-select, active high |
| ack_o | output | 1 | Transfer acknowledge |
| berr_o | output | 1 | Bus error request |
| wp_err_o | output | 1 | Sticky write-protect error flag |
| par_chk_o | output | 1 | Parity-check enable |

## Verification
The bench builds the block with AW=12, WAIT_W=4 and IS_BANK0=1. With a 12-bit address and random masks that select only a few bits, random addresses land on both the hit side and the miss side of the compare. Wait counts up to 15 are drawn, so the longest cycle of 17 phases and the shortest of 2 both occur. Because the block is built as bank 0, the reset strap is observable: the bench resets twice, once with the strap high and once with it low.

// File: rtl/csb_pkg.sv
package csb_pkg;

  // Single-bit fields of the bank configuration register.
  typedef struct packed {
    logic valid;
    logic wprot;
    logic par_en;
    logic early;
    logic dram;
  } cfg_flags_t;

endpackage

// File: rtl/csb_rst_sync.sv
module csb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/csb_cfg_regs.sv
module csb_cfg_regs import csb_pkg::*; #(
  parameter int AW       = 16,
  parameter int WAIT_W   = 4,
  parameter bit IS_BANK0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gcs_en_i,
  input  logic              we_i,
  input  cfg_flags_t        flags_i,
  input  logic [WAIT_W-1:0] waits_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     mask_i,
  output cfg_flags_t        flags_o,
  output logic [WAIT_W-1:0] waits_o,
  output logic [AW-1:0]     base_o,
  output logic [AW-1:0]     mask_o
);

  cfg_flags_t        flags_q, flags_d;
  logic [WAIT_W-1:0] waits_q, waits_d;
  logic [AW-1:0]     base_q, base_d, mask_q, mask_d;
  logic              valid_rst;

  // Only bank 0 takes its reset valid bit from the strap.
  generate
    if (IS_BANK0) begin : g_bank0
      assign valid_rst = gcs_en_i;
    end else begin : g_other
      assign valid_rst = 1'b0;
    end
  endgenerate

  always_comb begin
    flags_d = flags_q;
    waits_d = waits_q;
    base_d  = base_q;
    mask_d  = mask_q;
    if (we_i) begin
      flags_d = flags_i;
      waits_d = waits_i;
      base_d  = base_i;
      mask_d  = mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q       <= '0;
      flags_q.valid <= valid_rst;
      waits_q       <= '0;
      base_q        <= '0;
      mask_q        <= '0;
    end else begin
      flags_q <= flags_d;
      waits_q <= waits_d;
      base_q  <= base_d;
      mask_q  <= mask_d;
    end
  end

  assign flags_o = flags_q;
  assign waits_o = waits_q;
  assign base_o  = base_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/csb_match.sv
module csb_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic          valid_i,
  input  logic          wprot_i,
  input  logic          wr_i,
  output logic          hit_o,
  output logic          viol_o,
  output logic          go_o
);

  logic [AW-1:0] diff;

  always_comb begin
    diff   = (addr_i ^ base_i) & mask_i;
    hit_o  = valid_i && (diff == '0);
    viol_o = hit_o && wprot_i && wr_i;
    go_o   = hit_o && !viol_o;
  end

endmodule

// File: rtl/csb_seq.sv
module csb_seq #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              go_i,
  input  logic              viol_i,
  input  logic              bmon_i,
  input  logic              wr_i,
  input  logic              ext_i,
  input  logic              sync_i,
  input  logic              early_i,
  input  logic              dram_i,
  input  logic              par_en_i,
  input  logic [WAIT_W-1:0] waits_i,
  output logic              busy_o,
  output logic              cs_o,
  output logic              ack_o,
  output logic              par_o,
  output logic              berr_o,
  output logic              wperr_set_o
);

  localparam int PH_W = WAIT_W + 1;

  logic            busy_q, busy_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic [PH_W-1:0] last_q, last_d;
  logic            early_q, early_d;
  logic            par_q, par_d;
  logic            berr_q, berr_d;
  logic            accept, async_ext, at_last;

  assign accept    = start_i && !busy_q;
  assign async_ext = ext_i && !sync_i;
  assign at_last   = busy_q && (phase_q == last_q);

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    last_d  = last_q;
    early_d = early_q;
    par_d   = par_q;
    berr_d  = 1'b0;
    if (busy_q) begin
      if (at_last) begin
        busy_d = 1'b0;
      end else begin
        phase_d = phase_q + PH_W'(1);
      end
    end else if (start_i) begin
      if (go_i) begin
        busy_d  = 1'b1;
        phase_d = PH_W'(1);
        last_d  = {1'b0, waits_i} + PH_W'(2);
        early_d = early_i && wr_i && !(async_ext && !dram_i);
        par_d   = par_en_i && !async_ext;
      end else if (viol_i) begin
        berr_d = bmon_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      last_q  <= '0;
      early_q <= 1'b0;
      par_q   <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      last_q  <= last_d;
      early_q <= early_d;
      par_q   <= par_d;
      berr_q  <= berr_d;
    end
  end

  assign busy_o      = busy_q;
  assign cs_o        = busy_q && !(early_q && at_last);
  assign ack_o       = at_last;
  assign par_o       = busy_q && par_q;
  assign berr_o      = berr_q;
  assign wperr_set_o = accept && viol_i;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o); // R4
  AST_CS_PHASE1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && go_i) |=> cs_o); // R4
  AST_BERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |=> !berr_o); // R7
  AST_BUSY_IGNORES_AS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_last) |=> busy_q && (phase_q == $past(phase_q) + PH_W'(1))); // R13

endmodule

// File: rtl/csb_bank_ctrl.sv
module csb_bank_ctrl import csb_pkg::*; #(
  parameter int AW       = 16,
  parameter int WAIT_W   = 4,
  parameter bit IS_BANK0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gcs_en_i,
  input  logic              cfg_we_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_wprot_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_early_i,
  input  logic              cfg_dram_i,
  input  logic [WAIT_W-1:0] cfg_waits_i,
  input  logic [AW-1:0]     cfg_base_i,
  input  logic [AW-1:0]     cfg_mask_i,
  input  logic              stat_clr_i,
  input  logic              bmon_en_i,
  input  logic              bus_as_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_ext_i,
  input  logic              bus_sync_i,
  output logic              cs_o,
  output logic              ack_o,
  output logic              berr_o,
  output logic              wp_err_o,
  output logic              par_chk_o
);

  logic              rst_s_n;
  cfg_flags_t        wflags, flags;
  logic [WAIT_W-1:0] waits;
  logic [AW-1:0]     base, mask;
  logic              hit, viol, go;
  logic              busy, wperr_set;
  logic              wp_err_q, wp_err_d;

  csb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign wflags = '{valid:  cfg_valid_i, wprot: cfg_wprot_i, par_en: cfg_par_en_i,
                    early:  cfg_early_i, dram:  cfg_dram_i};

  csb_cfg_regs #(.AW(AW), .WAIT_W(WAIT_W), .IS_BANK0(IS_BANK0)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .gcs_en_i (gcs_en_i),
    .we_i     (cfg_we_i),
    .flags_i  (wflags),
    .waits_i  (cfg_waits_i),
    .base_i   (cfg_base_i),
    .mask_i   (cfg_mask_i),
    .flags_o  (flags),
    .waits_o  (waits),
    .base_o   (base),
    .mask_o   (mask)
  );

  csb_match #(.AW(AW)) u_match (
    .addr_i  (bus_addr_i),
    .base_i  (base),
    .mask_i  (mask),
    .valid_i (flags.valid),
    .wprot_i (flags.wprot),
    .wr_i    (bus_wr_i),
    .hit_o   (hit),
    .viol_o  (viol),
    .go_o    (go)
  );

  csb_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start_i     (bus_as_i),
    .go_i        (go),
    .viol_i      (viol),
    .bmon_i      (bmon_en_i),
    .wr_i        (bus_wr_i),
    .ext_i       (bus_ext_i),
    .sync_i      (bus_sync_i),
    .early_i     (flags.early),
    .dram_i      (flags.dram),
    .par_en_i    (flags.par_en),
    .waits_i     (waits),
    .busy_o      (busy),
    .cs_o        (cs_o),
    .ack_o       (ack_o),
    .par_o       (par_chk_o),
    .berr_o      (berr_o),
    .wperr_set_o (wperr_set)
  );

  // Sticky protection error: set has priority over the write-one clear.
  always_comb begin
    wp_err_d = wp_err_q;
    if (wperr_set) begin
      wp_err_d = 1'b1;
    end else if (stat_clr_i) begin
      wp_err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wp_err_q <= 1'b0;
    end else begin
      wp_err_q <= wp_err_d;
    end
  end

  assign wp_err_o = wp_err_q;

  AST_INVALID_NO_START: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_as_i && !busy && !flags.valid) |=> !cs_o && !ack_o); // R2
  AST_BERR_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    berr_o |-> !cs_o && !ack_o); // R5
  AST_WPERR_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wp_err_o && !stat_clr_i) |=> wp_err_o); // R6
  AST_WPERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!wp_err_o && !(bus_as_i && hit && bus_wr_i)) |=> !wp_err_o); // R6
  AST_PAR_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    par_chk_o |-> busy); // R8

endmodule

// File: tb/csb_bank_ctrl_bench.sv
module csb_bank_ctrl_bench;

  localparam int AW = 12;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic gcs_en, cfg_we, c_valid, c_wprot, c_par, c_early, c_dram;
  logic [WW-1:0] c_waits;
  logic [AW-1:0] c_base, c_mask;
  logic stat_clr, bmon, as, wr, ext, sync;
  logic [AW-1:0] addr;
  logic cs, ack, berr, wperr, par;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // bench model of the register contents
  bit m_valid, m_wp, m_par, m_early, m_dram, m_wperr;
  int m_waits;
  logic [AW-1:0] m_base, m_mask;
  // pending mid-cycle write contents
  bit n_valid, n_wp, n_par, n_early, n_dram;
  int n_waits;
  logic [AW-1:0] n_base, n_mask;

  always #5 clk = ~clk;

  csb_bank_ctrl #(.AW(AW), .WAIT_W(WW), .IS_BANK0(1'b1)) u_csb_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .gcs_en_i(gcs_en), .cfg_we_i(cfg_we),
    .cfg_valid_i(c_valid), .cfg_wprot_i(c_wprot), .cfg_par_en_i(c_par),
    .cfg_early_i(c_early), .cfg_dram_i(c_dram), .cfg_waits_i(c_waits),
    .cfg_base_i(c_base), .cfg_mask_i(c_mask), .stat_clr_i(stat_clr),
    .bmon_en_i(bmon), .bus_as_i(as), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_ext_i(ext), .bus_sync_i(sync), .cs_o(cs), .ack_o(ack),
    .berr_o(berr), .wp_err_o(wperr), .par_chk_o(par)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit f_hit(input logic [AW-1:0] a);
    return m_valid && (((a ^ m_base) & m_mask) == '0);
  endfunction

  function automatic int f_len();
    return m_waits + 2;
  endfunction

  task automatic do_reset(input bit strap);
    gcs_en = strap; rst_n = 1'b0;
    cfg_we = 0; c_valid = 0; c_wprot = 0; c_par = 0; c_early = 0; c_dram = 0;
    c_waits = '0; c_base = '0; c_mask = '0; stat_clr = 0; bmon = 0;
    as = 0; addr = '0; wr = 0; ext = 0; sync = 1;
    repeat (3) @(negedge clk);
    chk("R1", "cs in reset", int'(cs), 0);
    chk("R1", "ack in reset", int'(ack), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "berr after reset", int'(berr), 0);
    chk("R1", "wp_err after reset", int'(wperr), 0);
    chk("R1", "par after reset", int'(par), 0);
    m_valid = strap; m_wp = 0; m_par = 0; m_early = 0; m_dram = 0;
    m_waits = 0; m_base = '0; m_mask = '0; m_wperr = 0;
  endtask

  task automatic set_cfg(input bit v, input bit p, input bit pe, input bit e, input bit d,
                         input int w, input logic [AW-1:0] b, input logic [AW-1:0] m);
    @(negedge clk);
    cfg_we = 1; c_valid = v; c_wprot = p; c_par = pe; c_early = e; c_dram = d;
    c_waits = WW'(w); c_base = b; c_mask = m;
    @(negedge clk);
    cfg_we = 0;
    m_valid = v; m_wp = p; m_par = pe; m_early = e; m_dram = d;
    m_waits = w; m_base = b; m_mask = m;
  endtask

  task automatic do_access(input string tag, input logic [AW-1:0] a, input bit w,
                           input bit x, input bit s, input bit bm,
                           input bit mid_wr, input bit as_again);
    bit hit, viol, go, eff_early, pe;
    int len, cs_cnt, cs_first, ack_cnt, ack_k, par_cnt, berr_cnt, berr_k;
    string rq;
    hit = f_hit(a);
    viol = hit && m_wp && w;
    go = hit && !viol;
    len = f_len();
    eff_early = m_early && w && !(x && !s && !m_dram);
    pe = m_par && !(x && !s);
    cs_cnt = 0; cs_first = 0; ack_cnt = 0; ack_k = 0; par_cnt = 0; berr_cnt = 0; berr_k = 0;
    @(negedge clk);
    as = 1; addr = a; wr = w; ext = x; sync = s; bmon = bm;
    @(negedge clk);
    as = 0;
    for (int k = 1; k <= 20; k++) begin
      if (k > 1) @(negedge clk);
      if (cs) begin cs_cnt++; if (cs_first == 0) cs_first = k; end
      if (ack) begin ack_cnt++; ack_k = k; end
      if (par) par_cnt++;
      if (berr) begin berr_cnt++; berr_k = k; end
      if (mid_wr && k == 2) begin
        cfg_we = 1; c_valid = n_valid; c_wprot = n_wp; c_par = n_par;
        c_early = n_early; c_dram = n_dram; c_waits = WW'(n_waits);
        c_base = n_base; c_mask = n_mask;
      end
      if (mid_wr && k == 3) cfg_we = 0;
      if (as_again && k == 3) begin as = 1; addr = a; end
      if (as_again && k == 4) as = 0;
    end
    rq = !m_valid ? "R2" : (viol ? "R5" : tag);
    chk(rq, "cs first phase", cs_first, go ? 1 : 0);
    chk(eff_early ? "R10" : rq, "cs count", cs_cnt, go ? len - int'(eff_early) : 0);
    chk(rq, "ack count", ack_cnt, go ? 1 : 0);
    chk("R4", "ack phase", ack_k, go ? len : 0);
    chk((x && !s) ? "R9" : "R8", "par count", par_cnt, (go && pe) ? len : 0);
    chk("R7", "berr count", berr_cnt, (viol && bm) ? 1 : 0);
    chk("R7", "berr phase", berr_k, (viol && bm) ? 1 : 0);
    if (viol) m_wperr = 1;
    chk("R6", "wp_err flag", int'(wperr), int'(m_wperr));
    if (mid_wr) begin
      m_valid = n_valid; m_wp = n_wp; m_par = n_par; m_early = n_early;
      m_dram = n_dram; m_waits = n_waits; m_base = n_base; m_mask = n_mask;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
    m_wperr = 0;
    chk("R6", "wp_err after clear", int'(wperr), 0);
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_err++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'd7321);
    // R1: strap high makes bank 0 valid with an all-match mask, zero waits
    do_reset(1'b1);
    do_access("R1", 12'h5A5, 0, 0, 1, 0, 0, 0);
    // R1: strap low leaves bank invalid (R2 no termination)
    do_reset(1'b0);
    do_access("R2", 12'h123, 1, 0, 1, 1, 0, 0);
    // R3: base/mask compare, hit and miss
    set_cfg(1, 0, 0, 0, 0, 1, 12'hA00, 12'hF00);
    do_access("R3", 12'hA7F, 0, 0, 1, 0, 0, 0);
    do_access("R3", 12'hB00, 0, 0, 1, 0, 0, 0);
    // R4: longest cycle
    set_cfg(1, 0, 1, 0, 0, 15, 12'h000, 12'h000);
    do_access("R4", 12'h001, 1, 0, 1, 0, 0, 0);
    // R5/R6/R7: protected bank, read ok, write blocked
    set_cfg(1, 1, 0, 0, 0, 2, 12'h000, 12'h000);
    do_access("R5", 12'h010, 0, 0, 1, 1, 0, 0);
    do_access("R5", 12'h010, 1, 0, 1, 1, 0, 0);
    do_access("R7", 12'h020, 1, 0, 1, 0, 0, 0);
    clear_flag();
    // R8/R9: parity and async external master
    set_cfg(1, 0, 1, 0, 0, 3, 12'h000, 12'h000);
    do_access("R8", 12'h030, 0, 0, 0, 0, 0, 0);
    do_access("R9", 12'h030, 0, 1, 0, 0, 0, 0);
    // R10/R11: early release
    set_cfg(1, 0, 0, 1, 0, 2, 12'h000, 12'h000);
    do_access("R10", 12'h040, 1, 0, 1, 0, 0, 0);
    do_access("R10", 12'h040, 0, 0, 1, 0, 0, 0);
    do_access("R11", 12'h040, 1, 1, 0, 0, 0, 0);
    set_cfg(1, 0, 0, 1, 1, 2, 12'h000, 12'h000);
    do_access("R11", 12'h040, 1, 1, 0, 0, 0, 0);
    // R12: mid-cycle configuration write
    set_cfg(1, 0, 1, 0, 0, 3, 12'h000, 12'h000);
    n_valid = 1; n_wp = 0; n_par = 0; n_early = 1; n_dram = 0; n_waits = 10;
    n_base = '0; n_mask = '0;
    do_access("R12", 12'h050, 1, 0, 1, 0, 1, 0);
    do_access("R12", 12'h050, 1, 0, 1, 0, 0, 0);
    // R13: strobe during busy cycle
    set_cfg(1, 0, 0, 0, 0, 4, 12'h000, 12'h000);
    do_access("R13", 12'h060, 0, 0, 1, 0, 0, 1);
    // random mix
    for (int i = 0; i < 150; i++) begin
      if (i % 10 == 0)
        set_cfg(($urandom % 8) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                $urandom % 2, $urandom % 16, AW'($urandom), AW'($urandom) & 12'h90A);
      do_access("R3", AW'($urandom), $urandom % 2, $urandom % 2, $urandom % 2,
                $urandom % 2, 0, 0);
      if (i % 25 == 24) clear_flag();
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule